// File: doc/BRIEF.md
# Channel Page Registers and Physical Address Builder

This block holds, for each of four transfer channels, an 8-bit page byte and an optional 8-bit upper-page byte. It then joins them with the channel's 16-bit running address to produce a 31-bit physical memory address. Software reaches the page bytes through two port windows, each with eight offsets. Only four offsets in each window belong to a channel; the other four are holes.

Each write carries a window strobe, a 3-bit offset and a data byte. A read selects a window and an offset and gets the stored byte back on the same cycle. The address side is driven by the transfer engine. It presents a channel number and that channel's current 16-bit address, and the block returns the full physical address with no delay. Address counting and channel arbitration sit outside this block.

A build parameter removes the upper-page window. In that build, the upper-page bytes act as permanent zeros.

Top module: `dma_page_addr`

## Requirements
- R1: After reset, every page and upper-page byte reads as 0x00, and the address bits above bit 15 are zero for every channel.
- R2: Offset 7 selects channel 0, offset 3 selects channel 1, offset 1 selects channel 2 and offset 2 selects channel 3. A write is stored one clock edge after it is presented.
- R3: A write to offset 0, 4, 5 or 6 in either window changes no stored byte.
- R4: A read of offset 0, 4, 5 or 6 in either window returns 0x00.
- R5: The upper-page window (read-window select = 1, write strobe `hp_wr`) uses the same offset-to-channel map as the page window (read-window select = 0, write strobe `pg_wr`).
- R6: The physical address is built from three fields. Bits 30:24 are the low seven bits of the selected channel's upper-page byte. Bits 23:16 are its page byte. Bits 15:0 are `cur_addr`. The address changes only when a write occurs or the channel select changes.
- R7: A read of a valid offset returns all eight stored bits, including bit 7 of an upper-page byte that takes no part in the address.
- R8: With `HIGH_PAGE_EN` = 0, writes to the upper-page window are ignored, reads of it return 0x00, and address bits 30:24 are always zero.
- R9: A page write and an upper-page write issued in the same cycle are both stored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| pg_wr | input | 1 | Write strobe for the page window |
| hp_wr | input | 1 | Write strobe for the upper-page window |
| port_off | input | 3 | Offset within the window for writes |
| wr_data | input | 8 | Write data byte |
| rd_win | input | 1 | Read window select: 0 page, 1 upper page |
| rd_off | input | 3 | Offset within the window for reads |
| rd_data | output | 8 | Read data byte, combinational |
| chan_sel | input | 2 | Channel whose address is built |
| cur_addr | input | 16 | Current 16-bit address of that channel |
| phys_addr | output | 31 | Composed physical address |

## Verification
The hardest case is showing that a write to a hole leaves the state untouched. The ports hold no per-write acknowledgement, so a dropped write looks the same as one that silently went to another channel. To expose this, the bench first loads every channel with a distinct byte in both windows. It then writes 0xFF to each hole. Afterwards it reads back all four channels and builds the address for each one, so a write that leaked to any channel shows up as a changed byte. The disabled-window build is checked with a second instance that shares the same stimulus.

// File: rtl/pgaddr_pkg.sv
package pgaddr_pkg;

    localparam int NUM_CH    = 4;
    localparam int CH_W      = $clog2(NUM_CH);
    localparam int OFF_W     = 3;
    localparam int BYTE_W    = 8;
    localparam int HP_USED_W = 7;
    localparam int CUR_W     = 16;
    localparam int PHYS_W    = HP_USED_W + BYTE_W + CUR_W;

    typedef struct packed {
        logic            hit;
        logic [CH_W-1:0] ch;
    } chan_hit_t;

    typedef enum logic {
        WIN_PAGE = 1'b0,
        WIN_HIGH = 1'b1
    } win_t;

    // Sparse offset map: only four offsets reach a channel.
    function automatic chan_hit_t decode_off(input logic [OFF_W-1:0] off);
        chan_hit_t r;
        case (off)
            3'd7:    r = '{hit: 1'b1, ch: 2'd0};
            3'd3:    r = '{hit: 1'b1, ch: 2'd1};
            3'd1:    r = '{hit: 1'b1, ch: 2'd2};
            3'd2:    r = '{hit: 1'b1, ch: 2'd3};
            default: r = '{hit: 1'b0, ch: 2'd0};
        endcase
        return r;
    endfunction

endpackage

// File: rtl/pgaddr_decode.sv
module pgaddr_decode
    import pgaddr_pkg::*;
(
    input  logic [OFF_W-1:0] off,
    output chan_hit_t        hit
);
    always_comb hit = decode_off(off);
endmodule

// File: rtl/pgaddr_bank.sv
module pgaddr_bank
    import pgaddr_pkg::*;
#(
    parameter bit ENABLE = 1'b1,
    parameter int SEL_W  = BYTE_W
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     we,
    input  chan_hit_t                wr_hit,
    input  logic [BYTE_W-1:0]        wr_data,
    input  chan_hit_t                rd_hit,
    output logic [BYTE_W-1:0]        rd_data,
    input  logic [CH_W-1:0]          sel_ch,
    output logic [SEL_W-1:0]         sel_val,
    output logic [NUM_CH*BYTE_W-1:0] flat
);
    logic [BYTE_W-1:0] q [NUM_CH];

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic hit_me;
        assign hit_me = ENABLE && we && wr_hit.hit && (wr_hit.ch == CH_W'(c));
        always_ff @(posedge clk) begin
            if (rst)
                q[c] <= '0;
            else if (hit_me)
                q[c] <= wr_data;
        end
        assign flat[c*BYTE_W +: BYTE_W] = q[c];
    end

    always_comb begin
        rd_data = '0;
        if (ENABLE && rd_hit.hit)
            rd_data = q[rd_hit.ch];
    end

    always_comb sel_val = ENABLE ? q[sel_ch][SEL_W-1:0] : '0;
endmodule

// File: rtl/pgaddr_compose.sv
module pgaddr_compose
    import pgaddr_pkg::*;
(
    input  logic [HP_USED_W-1:0] hp_part,
    input  logic [BYTE_W-1:0]    pg_part,
    input  logic [CUR_W-1:0]     cur,
    output logic [PHYS_W-1:0]    phys
);
    always_comb phys = {hp_part, pg_part, cur};
endmodule

// File: rtl/dma_page_addr.sv
module dma_page_addr
    import pgaddr_pkg::*;
#(
    parameter bit HIGH_PAGE_EN = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pg_wr,
    input  logic              hp_wr,
    input  logic [OFF_W-1:0]  port_off,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              rd_win,
    input  logic [OFF_W-1:0]  rd_off,
    output logic [BYTE_W-1:0] rd_data,
    input  logic [CH_W-1:0]   chan_sel,
    input  logic [CUR_W-1:0]  cur_addr,
    output logic [PHYS_W-1:0] phys_addr
);
    chan_hit_t wr_hit, rd_hit;
    logic [BYTE_W-1:0]        pg_rd, hp_rd;
    logic [BYTE_W-1:0]        pg_sel;
    logic [HP_USED_W-1:0]     hp_sel;
    logic [NUM_CH*BYTE_W-1:0] page_flat, high_flat;

    pgaddr_decode u_wr_dec (.off(port_off), .hit(wr_hit));
    pgaddr_decode u_rd_dec (.off(rd_off),   .hit(rd_hit));

    pgaddr_bank #(.ENABLE(1'b1), .SEL_W(BYTE_W)) u_page (
        .clk(clk), .rst(rst), .we(pg_wr), .wr_hit(wr_hit), .wr_data(wr_data),
        .rd_hit(rd_hit), .rd_data(pg_rd), .sel_ch(chan_sel), .sel_val(pg_sel),
        .flat(page_flat)
    );

    pgaddr_bank #(.ENABLE(HIGH_PAGE_EN), .SEL_W(HP_USED_W)) u_high (
        .clk(clk), .rst(rst), .we(hp_wr), .wr_hit(wr_hit), .wr_data(wr_data),
        .rd_hit(rd_hit), .rd_data(hp_rd), .sel_ch(chan_sel), .sel_val(hp_sel),
        .flat(high_flat)
    );

    always_comb rd_data = (win_t'(rd_win) == WIN_HIGH) ? hp_rd : pg_rd;

    pgaddr_compose u_comp (
        .hp_part(hp_sel), .pg_part(pg_sel), .cur(cur_addr), .phys(phys_addr)
    );
endmodule

// File: rtl/pgaddr_checker.sv
module pgaddr_checker
    import pgaddr_pkg::*;
#(
    parameter bit HIGH_EN = 1'b1
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     pg_wr,
    input logic                     hp_wr,
    input logic [OFF_W-1:0]         port_off,
    input logic [BYTE_W-1:0]        wr_data,
    input logic                     rd_win,
    input logic [OFF_W-1:0]         rd_off,
    input logic [BYTE_W-1:0]        rd_data,
    input logic [CH_W-1:0]          chan_sel,
    input logic [PHYS_W-1:0]        phys_addr,
    input logic [NUM_CH*BYTE_W-1:0] page_flat,
    input logic [NUM_CH*BYTE_W-1:0] high_flat
);
    logic off_hole, rd_hole;
    assign off_hole = (port_off == 3'd0) || (port_off == 3'd4) || (port_off == 3'd5) || (port_off == 3'd6);
    assign rd_hole  = (rd_off == 3'd0) || (rd_off == 3'd4) || (rd_off == 3'd5) || (rd_off == 3'd6);

    p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (page_flat == '0 && high_flat == '0 && phys_addr[PHYS_W-1:CUR_W] == '0));

    p_ch0_write_lands_r2: assert property (@(posedge clk) disable iff (rst)
        (pg_wr && port_off == 3'd7) |=> (page_flat[BYTE_W-1:0] == $past(wr_data)));

    p_hole_write_ignored_r3: assert property (@(posedge clk) disable iff (rst)
        ((pg_wr || hp_wr) && off_hole) |=> ($stable(page_flat) && $stable(high_flat)));

    p_hole_read_zero_r4: assert property (@(posedge clk) disable iff (rst)
        rd_hole |-> (rd_data == '0));

    p_addr_upper_stable_r6: assert property (@(posedge clk) disable iff (rst)
        (!pg_wr && !hp_wr) ##1 $stable(chan_sel) |-> $stable(phys_addr[PHYS_W-1:CUR_W]));

    p_high_off_zero_r8: assert property (@(posedge clk) disable iff (rst)
        !HIGH_EN |-> (phys_addr[PHYS_W-1:CUR_W+BYTE_W] == '0 && (rd_win ? rd_data == '0 : 1'b1)));
endmodule

bind dma_page_addr pgaddr_checker #(.HIGH_EN(HIGH_PAGE_EN)) u_chk (
    .clk(clk), .rst(rst), .pg_wr(pg_wr), .hp_wr(hp_wr), .port_off(port_off),
    .wr_data(wr_data), .rd_win(rd_win), .rd_off(rd_off), .rd_data(rd_data),
    .chan_sel(chan_sel), .phys_addr(phys_addr), .page_flat(page_flat),
    .high_flat(high_flat)
);

// File: tb/test_dma_page_addr.sv
module test_dma_page_addr;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        pg_wr = 1'b0, hp_wr = 1'b0;
    logic [2:0]  port_off = '0;
    logic [7:0]  wr_data = '0;
    logic        rd_win = 1'b0;
    logic [2:0]  rd_off = '0;
    logic [1:0]  chan_sel = '0;
    logic [15:0] cur_addr = '0;
    logic [7:0]  rd_data, rd_data_n;
    logic [30:0] phys_addr, phys_addr_n;

    int checks = 0, errors = 0, cycles = 0;
    logic [7:0] exp_pg [4];
    logic [7:0] exp_hp [4];

    always #2 clk = ~clk;

    dma_page_addr #(.HIGH_PAGE_EN(1'b1)) i_dma_page_addr (
        .clk(clk), .rst(rst), .pg_wr(pg_wr), .hp_wr(hp_wr), .port_off(port_off),
        .wr_data(wr_data), .rd_win(rd_win), .rd_off(rd_off), .rd_data(rd_data),
        .chan_sel(chan_sel), .cur_addr(cur_addr), .phys_addr(phys_addr)
    );

    dma_page_addr #(.HIGH_PAGE_EN(1'b0)) i_dma_page_addr_nohp (
        .clk(clk), .rst(rst), .pg_wr(pg_wr), .hp_wr(hp_wr), .port_off(port_off),
        .wr_data(wr_data), .rd_win(rd_win), .rd_off(rd_off), .rd_data(rd_data_n),
        .chan_sel(chan_sel), .cur_addr(cur_addr), .phys_addr(phys_addr_n)
    );

    function automatic int off2ch(input logic [2:0] off);
        case (off)
            3'd7: return 0;
            3'd3: return 1;
            3'd1: return 2;
            3'd2: return 3;
            default: return -1;
        endcase
    endfunction

    function automatic logic [2:0] ch2off(input int ch);
        case (ch)
            0: return 3'd7;
            1: return 3'd3;
            2: return 3'd1;
            default: return 3'd2;
        endcase
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // Inputs change on the falling edge; a write lands at the next rising edge.
    task automatic do_write(input logic pg, input logic hp, input logic [2:0] off, input logic [7:0] d);
        @(negedge clk);
        pg_wr = pg; hp_wr = hp; port_off = off; wr_data = d;
        @(negedge clk);
        pg_wr = 1'b0; hp_wr = 1'b0;
        if (off2ch(off) >= 0) begin
            if (pg) exp_pg[off2ch(off)] = d;
            if (hp) exp_hp[off2ch(off)] = d;
        end
    endtask

    task automatic rd_chk(input string req, input logic win, input logic [2:0] off, input logic [7:0] exp);
        rd_win = win; rd_off = off;
        #1;
        chk(req, {24'd0, rd_data}, {24'd0, exp});
    endtask

    task automatic addr_chk(input string req, input int ch, input logic [15:0] cur);
        chan_sel = ch[1:0]; cur_addr = cur;
        #1;
        chk(req, {1'b0, phys_addr}, {1'b0, exp_hp[ch][6:0], exp_pg[ch], cur});
    endtask

    task automatic t_reset;
        for (int o = 0; o < 8; o++) begin
            rd_chk("R1 page reset", 1'b0, o[2:0], 8'h00);
            rd_chk("R1 high reset", 1'b1, o[2:0], 8'h00);
        end
        for (int c = 0; c < 4; c++) addr_chk("R1 addr reset", c, 16'h1234);
    endtask

    task automatic t_map;
        do_write(1'b1, 1'b0, 3'd7, 8'h11);
        do_write(1'b1, 1'b0, 3'd3, 8'h22);
        do_write(1'b1, 1'b0, 3'd1, 8'h33);
        do_write(1'b1, 1'b0, 3'd2, 8'h44);
        for (int c = 0; c < 4; c++) begin
            addr_chk("R2 map addr", c, 16'hBEEF);
            rd_chk("R2 map readback", 1'b0, ch2off(c), exp_pg[c]);
        end
        chk("R2 ch0 byte", {24'd0, exp_pg[0]}, 32'h11);
    endtask

    task automatic t_high;
        do_write(1'b0, 1'b1, 3'd7, 8'h81);
        do_write(1'b0, 1'b1, 3'd3, 8'h7F);
        do_write(1'b0, 1'b1, 3'd1, 8'hC5);
        do_write(1'b0, 1'b1, 3'd2, 8'h06);
        for (int c = 0; c < 4; c++) begin
            rd_chk("R7 full byte readback", 1'b1, ch2off(c), exp_hp[c]);
            addr_chk("R5 R6 high map addr", c, 16'h0F0F);
        end
        chan_sel = 2'd0; cur_addr = 16'h0000; #1;
        chk("R6 bit7 excluded", {1'b0, phys_addr}, {1'b0, 7'h01, 8'h11, 16'h0000});
        chan_sel = 2'd2; cur_addr = 16'hFFFF; #1;
        chk("R6 ch2 compose", {1'b0, phys_addr}, {1'b0, 7'h45, 8'h33, 16'hFFFF});
    endtask

    task automatic t_holes;
        logic [2:0] holes [4] = '{3'd0, 3'd4, 3'd5, 3'd6};
        foreach (holes[i]) do_write(1'b1, 1'b1, holes[i], 8'hFF);
        for (int c = 0; c < 4; c++) begin
            rd_chk("R3 page kept", 1'b0, ch2off(c), exp_pg[c]);
            rd_chk("R3 high kept", 1'b1, ch2off(c), exp_hp[c]);
            addr_chk("R3 addr kept", c, 16'h5A5A);
        end
        foreach (holes[i]) begin
            rd_chk("R4 page hole read", 1'b0, holes[i], 8'h00);
            rd_chk("R4 high hole read", 1'b1, holes[i], 8'h00);
        end
    endtask

    task automatic t_same_cycle;
        do_write(1'b1, 1'b1, 3'd3, 8'hA7);
        rd_chk("R9 page same cycle", 1'b0, 3'd3, 8'hA7);
        rd_chk("R9 high same cycle", 1'b1, 3'd3, 8'hA7);
        addr_chk("R9 addr same cycle", 1, 16'h0001);
    endtask

    task automatic t_no_high;
        chan_sel = 2'd0; cur_addr = 16'h4321; rd_win = 1'b1; rd_off = 3'd7;
        #1;
        chk("R8 high read zero", {24'd0, rd_data_n}, 32'h0);
        chk("R8 addr top zero", {1'b0, phys_addr_n}, {1'b0, 7'h00, exp_pg[0], 16'h4321});
        do_write(1'b0, 1'b1, 3'd7, 8'h55);
        rd_win = 1'b1; rd_off = 3'd7; #1;
        chk("R8 high write ignored", {24'd0, rd_data_n}, 32'h0);
        chk("R8 addr after high write", {1'b0, phys_addr_n}, {1'b0, 7'h00, exp_pg[0], 16'h4321});
        rd_win = 1'b0; #1;
        chk("R8 page still usable", {24'd0, rd_data_n}, {24'd0, exp_pg[0]});
    endtask

    initial begin
        for (int c = 0; c < 4; c++) begin exp_pg[c] = 8'h00; exp_hp[c] = 8'h00; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_map();
        t_high();
        t_holes();
        t_same_cycle();
        t_no_high();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            checks++; errors++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule